// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block turns single read and write requests from inside the chip into pin-level cycles for asynchronous SRAM, NOR or NAND parts that sit on up to four chip selects. Each chip select owns a 64 MB window: a request carries a chip-select index and a byte offset. Every access is split into a setup phase, a strobe phase and a hold phase. Each phase length is a cycle count held in static configuration inputs, kept separately per chip select and per direction.

Each chip select can be configured in four ways. It can have an 8-bit or 16-bit data path. It can allow a slow device to stretch the strobe through its wait pin, with a bounded timeout. It can drive its select line only while the strobe is active. It can require a minimum idle gap before an access that changes chip select or direction. One response per request returns the read data and an error flag. The error flag is raised when a wait-stretched strobe is cut off by the timeout.

Top module: `async_mem_seq`

## Requirements
- R1: An access holds its selected chip select low for exactly S setup cycles, then drives the strobe (oe_n low for a read, we_n low for a write, never both) for exactly T cycles, then keeps the chip select low for exactly H hold cycles. S, T and H come from the read or write count fields of the addressed chip select. Field i of each count vector is bits [4i+3:4i].
- R2: A programmed count of 0 gives a phase of exactly one cycle.
- R3: No more than one chip-select line is low in any cycle. The line that goes low is the one whose index the request carried.
- R4: When the select-strobe bit of a chip select is 1, its line is low only during strobe cycles. No select is seen in setup or hold.
- R5: With the request already waiting, an access whose chip select or direction differs from the previous access starts after exactly max(G,1) cycles with every select high. G is the 3-bit turnaround field of the new access's chip select (bits [3i+2:3i]). Earlier idle cycles count toward G.
- R6: A read after a read, or a write after a write, on the same chip select starts after exactly one deselected cycle, whatever G is.
- R7: When the wait-enable bit of the chip select is 1, the strobe continues past its T cycles while the wait pin, taken through two flops, reads 1. The hold phase begins on the first cycle that the synchronised wait reads 0. When the bit is 0, the wait pin has no effect on the strobe length.
- R8: If a stretched strobe reaches T plus the wait limit while the synchronised wait still reads 1, it ends there and the response has rsp_err = 1. If the synchronised wait reads 0 in that final cycle, rsp_err is 0.
- R9: With the width bit of a chip select at 1 (16 bits), mem_addr is the byte offset shifted right by one, mem_dout is the full write data, and read data is taken whole. With the width bit at 0 (8 bits), mem_addr is the offset, and the upper byte of both mem_dout and rsp_rdata is 0.
- R10: Read data is sampled from mem_din at the end of the last strobe cycle. rsp_valid pulses for one cycle right after the last hold cycle. rsp_rdata is 0 for writes.
- R11: After reset, all selects, oe_n and we_n are high, mem_dout_en and rsp_valid are 0, and req_ready is 1.
- R12: mem_dout_en is 1 in every setup, strobe and hold cycle of a write, and 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-select index |
| req_addr | input | 26 | Byte offset in the 64 MB window |
| req_wdata | input | 16 | Write data |
| cfg_rd_setup | input | 16 | Read setup counts, 4 bits per chip select |
| cfg_rd_strobe | input | 16 | Read strobe counts |
| cfg_rd_hold | input | 16 | Read hold counts |
| cfg_wr_setup | input | 16 | Write setup counts |
| cfg_wr_strobe | input | 16 | Write strobe counts |
| cfg_wr_hold | input | 16 | Write hold counts |
| cfg_turn | input | 12 | Turnaround gap, 3 bits per chip select |
| cfg_wait_en | input | 4 | Wait-pin strobe extension enable per chip select |
| cfg_sel_strobe | input | 4 | Select-only-during-strobe per chip select |
| cfg_wide | input | 4 | 1 = 16-bit device, 0 = 8-bit |
| cfg_wait_max | input | 8 | Maximum extra strobe cycles from the wait pin |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | 26 | Device address |
| mem_dout | output | 16 | Write data to the device |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Read data from the device |
| mem_wait | input | 4 | Per chip-select wait pins, active high |
| rsp_valid | output | 1 | Access complete, one-cycle pulse |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Wait timeout occurred |

## Verification
Two things can happen on the same cycle: the synchronised wait pin drops, and the extension counter reaches its limit. The bench provokes this by holding the wait pin high and releasing it at a chosen strobe cycle, counted from the observed oe_n. A release two cycles before the final cycle must give a full-length strobe with no error. A release one cycle later must give the same length with the error flag set. Release earlier in the strobe and a fully held pin are also run, and each strobe length is compared with the value worked out from the two-flop delay.

// File: rtl/async_mem_seq.sv
module async_mem_seq #(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  parameter int TA_W   = 3,
  parameter int WMAX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [$clog2(NUM_CS)-1:0] req_cs,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [NUM_CS*CNT_W-1:0]  cfg_rd_setup,
  input  logic [NUM_CS*CNT_W-1:0]  cfg_rd_strobe,
  input  logic [NUM_CS*CNT_W-1:0]  cfg_rd_hold,
  input  logic [NUM_CS*CNT_W-1:0]  cfg_wr_setup,
  input  logic [NUM_CS*CNT_W-1:0]  cfg_wr_strobe,
  input  logic [NUM_CS*CNT_W-1:0]  cfg_wr_hold,
  input  logic [NUM_CS*TA_W-1:0]   cfg_turn,
  input  logic [NUM_CS-1:0]        cfg_wait_en,
  input  logic [NUM_CS-1:0]        cfg_sel_strobe,
  input  logic [NUM_CS-1:0]        cfg_wide,
  input  logic [WMAX_W-1:0]        cfg_wait_max,
  output logic [NUM_CS-1:0]        mem_cs_n,
  output logic                     mem_oe_n,
  output logic                     mem_we_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_dout,
  output logic                     mem_dout_en,
  input  logic [DATA_W-1:0]        mem_din,
  input  logic [NUM_CS-1:0]        mem_wait,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_err
);

  localparam int CS_W   = $clog2(NUM_CS);
  localparam int HALF_W = DATA_W / 2;
  localparam int CW     = (CNT_W > TA_W) ? CNT_W : TA_W;

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_SETUP, S_STROBE, S_HOLD} state_t;

  state_t              state;
  logic [CW-1:0]       cnt;
  logic [CS_W-1:0]     cur_cs, last_cs;
  logic                cur_wr, last_wr;
  logic [ADDR_W-1:0]   cur_addr;
  logic [DATA_W-1:0]   cur_wdata, rdata_q;
  logic [WMAX_W-1:0]   ext_cnt;
  logic                err_q, rsp_q;
  logic [TA_W-1:0]     gap_cnt;
  logic [NUM_CS-1:0]   wait_m, wait_s;

  function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  // request-side decode
  logic [TA_W-1:0]  n_ta;
  logic [CNT_W-1:0] n_setup;
  logic [TA_W:0]    turn_len;
  logic             need_turn;

  assign n_ta      = cfg_turn[req_cs*TA_W +: TA_W];
  assign n_setup   = req_write ? cfg_wr_setup[req_cs*CNT_W +: CNT_W]
                               : cfg_rd_setup[req_cs*CNT_W +: CNT_W];
  assign turn_len  = {1'b0, n_ta} - {1'b0, gap_cnt} - 2'd2;
  assign need_turn = ((req_cs != last_cs) || (req_write != last_wr)) &&
                     (({1'b0, gap_cnt} + 1'b1) < {1'b0, n_ta});

  // current-access decode
  logic [CNT_W-1:0] c_setup, c_strobe, c_hold;
  logic             c_ew, c_ss, c_wait;

  assign c_setup  = cur_wr ? cfg_wr_setup[cur_cs*CNT_W +: CNT_W]  : cfg_rd_setup[cur_cs*CNT_W +: CNT_W];
  assign c_strobe = cur_wr ? cfg_wr_strobe[cur_cs*CNT_W +: CNT_W] : cfg_rd_strobe[cur_cs*CNT_W +: CNT_W];
  assign c_hold   = cur_wr ? cfg_wr_hold[cur_cs*CNT_W +: CNT_W]   : cfg_rd_hold[cur_cs*CNT_W +: CNT_W];
  assign c_ew     = cfg_wait_en[cur_cs];
  assign c_ss     = cfg_sel_strobe[cur_cs];
  assign c_wait   = wait_s[cur_cs];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_m <= '0;
      wait_s <= '0;
    end else begin
      wait_m <= mem_wait;
      wait_s <= wait_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      cur_cs    <= '0;
      cur_wr    <= 1'b0;
      last_cs   <= '0;
      last_wr   <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rdata_q   <= '0;
      ext_cnt   <= '0;
      err_q     <= 1'b0;
      rsp_q     <= 1'b0;
      gap_cnt   <= '1;
    end else begin
      rsp_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            cur_cs    <= req_cs;
            cur_wr    <= req_write;
            cur_addr  <= cfg_wide[req_cs] ? (req_addr >> 1) : req_addr;
            cur_wdata <= cfg_wide[req_cs] ? req_wdata
                                          : {{HALF_W{1'b0}}, req_wdata[HALF_W-1:0]};
            rdata_q   <= '0;
            err_q     <= 1'b0;
            if (need_turn) begin
              state <= S_TURN;
              cnt   <= CW'(turn_len);
            end else begin
              state <= S_SETUP;
              cnt   <= CW'(last_idx(n_setup));
            end
          end else if (gap_cnt != '1) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_TURN: begin
          if (cnt == '0) begin
            state <= S_SETUP;
            cnt   <= CW'(last_idx(c_setup));
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_SETUP: begin
          if (cnt == '0) begin
            state   <= S_STROBE;
            cnt     <= CW'(last_idx(c_strobe));
            ext_cnt <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (c_ew && c_wait && ext_cnt != cfg_wait_max) begin
            ext_cnt <= ext_cnt + 1'b1;
          end else begin
            state <= S_HOLD;
            cnt   <= CW'(last_idx(c_hold));
            err_q <= c_ew && c_wait;
            if (!cur_wr)
              rdata_q <= cfg_wide[cur_cs] ? mem_din
                                          : {{HALF_W{1'b0}}, mem_din[HALF_W-1:0]};
          end
        end
        S_HOLD: begin
          if (cnt == '0) begin
            state   <= S_IDLE;
            rsp_q   <= 1'b1;
            gap_cnt <= '0;
            last_cs <= cur_cs;
            last_wr <= cur_wr;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic in_acc, cs_on;
  assign in_acc = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
  assign cs_on  = c_ss ? (state == S_STROBE) : in_acc;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign mem_cs_n[i] = !(cs_on && (cur_cs == CS_W'(i)));
  end

  assign req_ready   = (state == S_IDLE);
  assign mem_oe_n    = !((state == S_STROBE) && !cur_wr);
  assign mem_we_n    = !((state == S_STROBE) && cur_wr);
  assign mem_dout_en = in_acc && cur_wr;
  assign mem_addr    = cur_addr;
  assign mem_dout    = cur_wdata;
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;
  assign rsp_err     = rsp_q && err_q;

  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r12_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_oe_n);
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r4_sel_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((~&mem_cs_n) && c_ss) |-> (!mem_oe_n || !mem_we_n));
  a_r8_err_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> cfg_wait_en[last_cs]);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_oe_n && mem_we_n && (&mem_cs_n) && !mem_dout_en));

endmodule

// File: tb/async_mem_seq_tb.sv
module async_mem_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_cs;
  logic [25:0] req_addr;
  logic [15:0] req_wdata;
  logic [15:0] cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold;
  logic [15:0] cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold;
  logic [11:0] cfg_turn;
  logic [3:0]  cfg_wait_en, cfg_sel_strobe, cfg_wide;
  logic [7:0]  cfg_wait_max;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_dout_en;
  logic [25:0] mem_addr;
  logic [15:0] mem_dout, mem_din;
  logic [3:0]  mem_wait;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;

  assign mem_din = mem_addr[15:0] ^ 16'hA5C3;

  async_mem_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .cfg_turn(cfg_turn), .cfg_wait_en(cfg_wait_en), .cfg_sel_strobe(cfg_sel_strobe),
    .cfg_wide(cfg_wide), .cfg_wait_max(cfg_wait_max),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_wait(mem_wait),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  typedef struct packed {
    logic [1:0]  cs;
    logic        wr;
    logic [25:0] addr;
    logic [15:0] wdata;
    logic [3:0]  su, st, ho, gap;
    logic [25:0] eaddr;
    logic [15:0] edout;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 26'h12,      16'h0,    4'd2, 4'd3, 4'd1, 4'd0, 26'h12,      16'h0},
    '{2'd0, 1'b0, 26'h34,      16'h0,    4'd2, 4'd3, 4'd1, 4'd1, 26'h34,      16'h0},
    '{2'd0, 1'b1, 26'h56,      16'hBEEF, 4'd1, 4'd2, 4'd2, 4'd3, 26'h56,      16'h00EF},
    '{2'd0, 1'b1, 26'h78,      16'h1234, 4'd1, 4'd2, 4'd2, 4'd1, 26'h78,      16'h0034},
    '{2'd1, 1'b0, 26'h1234,    16'h0,    4'd1, 4'd1, 4'd1, 4'd2, 26'h91A,     16'h0},
    '{2'd1, 1'b1, 26'h100,     16'h1357, 4'd3, 4'd1, 4'd1, 4'd2, 26'h80,      16'h1357},
    '{2'd0, 1'b0, 26'h3FFFFFF, 16'h0,    4'd2, 4'd3, 4'd1, 4'd3, 26'h3FFFFFF, 16'h0},
    '{2'd3, 1'b0, 26'h9,       16'h0,    4'd2, 4'd2, 4'd2, 4'd5, 26'h9,       16'h0},
    '{2'd3, 1'b0, 26'hA,       16'h0,    4'd2, 4'd2, 4'd2, 4'd1, 26'hA,       16'h0},
    '{2'd1, 1'b0, 26'h2,       16'h0,    4'd1, 4'd1, 4'd1, 4'd2, 26'h1,       16'h0}
  };

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_exp(input logic [25:0] a, input logic wide);
    return wide ? (a[15:0] ^ 16'hA5C3) : {8'h00, a[7:0] ^ 8'hC3};
  endfunction

  // pin monitor
  int ph = 0, idle_cnt = 100, n = 0, stray = 0, csbad = 0;
  int m_setup[64], m_strobe[64], m_hold[64], m_gap[64], m_cs[64], m_den[64];
  int m_addr[64], m_dout[64];
  bit m_rd[64], m_wr[64];

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit sel = ~&mem_cs_n;
      automatic bit stb = !mem_oe_n || !mem_we_n;
      if ($countones(~mem_cs_n) > 1) csbad++;
      if (ph == 0 && sel) begin
        m_gap[n] = idle_cnt; m_setup[n] = 0; m_strobe[n] = 0; m_hold[n] = 0;
        m_den[n] = 0; m_rd[n] = 0; m_wr[n] = 0; m_dout[n] = 0;
        for (int i = 0; i < 4; i++) if (!mem_cs_n[i]) m_cs[n] = i;
        ph = stb ? 2 : 1;
      end else if (ph == 1 && stb) begin
        ph = 2;
      end else if (ph == 2 && !stb) begin
        if (sel) ph = 3;
        else begin n++; idle_cnt = 0; ph = 0; end
      end else if (ph == 3 && !sel) begin
        n++; idle_cnt = 0; ph = 0;
      end
      case (ph)
        0: idle_cnt++;
        1: m_setup[n]++;
        2: begin
          m_strobe[n]++;
          m_addr[n] = int'(mem_addr);
          if (!mem_oe_n) m_rd[n] = 1;
          if (!mem_we_n) begin m_wr[n] = 1; m_dout[n] = int'(mem_dout); end
        end
        default: m_hold[n]++;
      endcase
      if (ph != 0 && mem_dout_en) m_den[n]++;
      if (ph == 0 && mem_dout_en) stray++;
    end
  end

  int rn = 0;
  int r_data[64];
  bit r_err[64];
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      r_data[rn] = int'(rsp_rdata);
      r_err[rn]  = rsp_err;
      rn++;
    end
  end

  task automatic send(input logic [1:0] cs, input logic wr, input logic [25:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_cs = cs; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int target);
    while (rn < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_wait(input int rel, input logic [25:0] a);
    mem_wait[3] = 1'b1;
    repeat (3) @(negedge clk);
    send(2'd3, 1'b0, a, 16'h0);
    if (rel > 0) begin
      automatic int k = 0;
      forever begin
        if (!mem_oe_n) k++;
        if (k == rel) break;
        @(negedge clk);
      end
      mem_wait[3] = 1'b0;
    end
    wait_rsp(rn + 1);
    mem_wait[3] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", rn, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_cs = '0; req_addr = '0; req_wdata = '0;
    mem_wait = '0;
    cfg_rd_setup  = {4'd2, 4'd1, 4'd0, 4'd2};
    cfg_rd_strobe = {4'd2, 4'd2, 4'd0, 4'd3};
    cfg_rd_hold   = {4'd2, 4'd1, 4'd0, 4'd1};
    cfg_wr_setup  = {4'd1, 4'd1, 4'd3, 4'd1};
    cfg_wr_strobe = {4'd1, 4'd2, 4'd1, 4'd2};
    cfg_wr_hold   = {4'd1, 4'd1, 4'd0, 4'd2};
    cfg_turn      = {3'd5, 3'd4, 3'd2, 3'd3};
    cfg_wait_en   = 4'b1000;
    cfg_sel_strobe = 4'b0100;
    cfg_wide      = 4'b0110;
    cfg_wait_max  = 8'd6;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(mem_cs_n == 4'hF, "R11 cs_n in reset", int'(mem_cs_n), 15);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n, "R11 strobes idle", int'({mem_cs_n, mem_oe_n, mem_we_n}), 63);
    chk(!mem_dout_en && !rsp_valid, "R11 drive and rsp low", int'({mem_dout_en, rsp_valid}), 0);
    chk(req_ready, "R11 ready", int'(req_ready), 1);

    // vector table, back-to-back
    for (int k = 0; k < NV; k++) send(TBL[k].cs, TBL[k].wr, TBL[k].addr, TBL[k].wdata);
    wait_rsp(NV);
    for (int k = 0; k < NV; k++) begin
      automatic vec_t v = TBL[k];
      automatic int den = v.wr ? int'(v.su) + int'(v.st) + int'(v.ho) : 0;
      chk(m_setup[k] == int'(v.su), $sformatf("R1 R2 setup v%0d", k), m_setup[k], int'(v.su));
      chk(m_strobe[k] == int'(v.st), $sformatf("R1 R2 strobe v%0d", k), m_strobe[k], int'(v.st));
      chk(m_hold[k] == int'(v.ho), $sformatf("R1 R2 hold v%0d", k), m_hold[k], int'(v.ho));
      chk(m_wr[k] == v.wr && m_rd[k] == !v.wr, $sformatf("R1 strobe kind v%0d", k), int'(m_wr[k]), int'(v.wr));
      chk(m_cs[k] == int'(v.cs), $sformatf("R3 select index v%0d", k), m_cs[k], int'(v.cs));
      if (v.gap != 0)
        chk(m_gap[k] == int'(v.gap), $sformatf("R5 R6 gap v%0d", k), m_gap[k], int'(v.gap));
      chk(m_addr[k] == int'(v.eaddr), $sformatf("R9 addr v%0d", k), m_addr[k], int'(v.eaddr));
      chk(m_den[k] == den, $sformatf("R12 drive cycles v%0d", k), m_den[k], den);
      if (v.wr) begin
        chk(m_dout[k] == int'(v.edout), $sformatf("R9 dout v%0d", k), m_dout[k], int'(v.edout));
        chk(r_data[k] == 0, $sformatf("R10 write rdata v%0d", k), r_data[k], 0);
      end else begin
        automatic int e = int'(rd_exp(v.eaddr, cfg_wide[v.cs]));
        chk(r_data[k] == e, $sformatf("R9 R10 rdata v%0d", k), r_data[k], e);
      end
      chk(!r_err[k], $sformatf("R8 no err v%0d", k), int'(r_err[k]), 0);
    end

    // R4 select-strobe mode, 16-bit read on cs2
    b = n;
    send(2'd2, 1'b0, 26'h40, 16'h0);
    wait_rsp(rn + 1);
    chk(m_setup[b] == 0 && m_hold[b] == 0, "R4 no select outside strobe", m_setup[b] + m_hold[b], 0);
    chk(m_strobe[b] == 2, "R4 select width", m_strobe[b], 2);
    chk(m_cs[b] == 2, "R3 R4 select index", m_cs[b], 2);
    chk(r_data[b] == int'(rd_exp(26'h20, 1'b1)), "R9 R4 rdata", r_data[b], int'(rd_exp(26'h20, 1'b1)));

    // R7 wait ignored when disabled
    b = n;
    mem_wait[0] = 1'b1;
    repeat (3) @(negedge clk);
    send(2'd0, 1'b0, 26'h5, 16'h0);
    wait_rsp(rn + 1);
    mem_wait[0] = 1'b0;
    chk(m_strobe[b] == 3, "R7 wait ignored strobe", m_strobe[b], 3);
    chk(!r_err[b], "R7 wait ignored err", int'(r_err[b]), 0);

    // R8 timeout with wait held
    b = n;
    run_wait(0, 26'h11);
    chk(m_strobe[b] == 8, "R8 timeout strobe", m_strobe[b], 8);
    chk(r_err[b], "R8 timeout err", int'(r_err[b]), 1);
    chk(m_setup[b] == 2 && m_hold[b] == 2, "R7 stretched setup/hold", m_setup[b] * 10 + m_hold[b], 22);

    // R7 release during extension
    b = n;
    run_wait(4, 26'h12);
    chk(m_strobe[b] == 6, "R7 release strobe", m_strobe[b], 6);
    chk(!r_err[b], "R7 release err", int'(r_err[b]), 0);
    chk(r_data[b] == int'(rd_exp(26'h12, 1'b0)), "R10 stretched rdata", r_data[b], int'(rd_exp(26'h12, 1'b0)));

    // R8 coincidence: release lands on last cycle
    b = n;
    run_wait(6, 26'h13);
    chk(m_strobe[b] == 8, "R8 late release strobe", m_strobe[b], 8);
    chk(!r_err[b], "R8 late release err", int'(r_err[b]), 0);

    // R8 one cycle later: timeout wins
    b = n;
    run_wait(7, 26'h14);
    chk(m_strobe[b] == 8, "R8 too-late release strobe", m_strobe[b], 8);
    chk(r_err[b], "R8 too-late release err", int'(r_err[b]), 1);

    chk(stray == 0, "R12 stray drive cycles", stray, 0);
    chk(csbad == 0, "R3 multiple selects", csbad, 0);
    chk(rn == n, "R10 one response per access", rn, n);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule